// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the 32-bit integer data path of a load/store processor's execute stage. Each cycle it receives a first operand and a second operand that an upstream barrel shifter has already shifted. It also receives the carry produced by that shifter, a 4-bit operation code and a set-flags bit. From these it produces a result, a register write-enable and the next values of the negative, zero, carry and overflow flags.

The operations fall into four groups:
- bitwise logic: and, or, exclusive-or, bit-clear, move and move-inverted;
- arithmetic: add, subtract and reverse subtract;
- carry-chained arithmetic: add, subtract and reverse subtract that take in the stored carry;
- compare/test: four operations that only update the flags.

The arithmetic is combinational. A thin registered wrapper holds the four flags between operations. The wrapper feeds the stored carry back into the carry-chained operations.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode encoding (4 bits) is 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC and 15 MVN. AND, EOR and ORR return the bitwise function of the two operands, and BIC returns first AND NOT second.
- R2: MOV returns the second operand and MVN returns its bitwise inverse. The first operand is ignored.
- R3: ADD returns first plus second, SUB returns first minus second and RSB returns second minus first, all modulo 2^32.
- R4: ADC adds the stored carry to first plus second. SBC computes first + NOT second + carry, and RSC computes second + NOT first + carry, so a clear carry acts as a borrow of one.
- R5: TST, TEQ, CMP and CMN (opcodes 8 to 11) never assert `wr_en`. Every other opcode asserts `wr_en` whenever `op_valid` is high, and `wr_en` is low whenever `op_valid` is low.
- R6: The flags register loads at a clock edge only when `op_valid` is high and either `set_flags` is high or the opcode is a compare/test. Otherwise it holds its value.
- R7: For the subtracting opcodes (SUB, RSB, SBC, RSC, CMP), C is the carry out of the inverted-operand addition, so C=1 means no borrow. For ADD, ADC and CMN, C is the carry out of bit 31.
- R8: For the logical opcodes (AND, EOR, ORR, BIC, MOV, MVN, TST, TEQ), a flag update sets C from `shift_carry` and leaves V unchanged.
- R9: On a flag update, N takes result bit 31 and Z is set exactly when the 32-bit result is zero. For compare/test opcodes, `result` still presents the value that the flags are computed from.
- R10: For arithmetic opcodes, V is set on two's-complement overflow: the two addends have the same sign and the sum has the opposite sign.
- R11: While `rst_n` is low, `flags` is 4'b0000. The bit order is [3]=N, [2]=Z, [1]=C, [0]=V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle (clock enable for the flags) |
| opcode | input | 4 | Operation code, encoding in R1 |
| set_flags | input | 1 | Request a flag update for non-compare opcodes |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the upstream shifter |
| result | output | 32 | Operation result (combinational) |
| wr_en | output | 1 | Write the result to the destination register |
| flags | output | 4 | Stored flags {N, Z, C, V} |

## Verification
On every cycle, the assertions check four things:
- the flags register holds when no update is due;
- compare/test opcodes never raise the write-enable;
- the stored N and Z follow the result that was presented at the updating edge;
- a logical update keeps V.

Only the bench's scenarios can show that each opcode produces the right 32-bit value and the right carry and overflow. The scenarios cover borrow versus no-borrow on subtraction, signed overflow at both sign boundaries, and the stored carry feeding ADC, SBC and RSC. They also show that reset clears the flags in the middle of a run.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_SUB = 4'd2,
    OP_RSB = 4'd3,
    OP_ADD = 4'd4,
    OP_ADC = 4'd5,
    OP_SBC = 4'd6,
    OP_RSC = 4'd7,
    OP_TST = 4'd8,
    OP_TEQ = 4'd9,
    OP_CMP = 4'd10,
    OP_CMN = 4'd11,
    OP_ORR = 4'd12,
    OP_MOV = 4'd13,
    OP_BIC = 4'd14,
    OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  // Compare/test group occupies opcodes 8..11.
  function automatic logic op_is_compare(input alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   y
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_BIC:         y = a & ~b;
      OP_MOV:         y = b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end

endmodule

// File: rtl/alu_adder_unit.sv
module alu_adder_unit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              inv_a,
  input  logic              inv_b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] x;
  logic [DATA_W-1:0] y;
  logic [DATA_W:0]   total;

  always_comb begin
    x     = inv_a ? ~a : a;
    y     = inv_b ? ~b : b;
    total = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    sum   = total[DATA_W-1:0];
    cout  = total[DATA_W];
    ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              shift_c,
  input  alu_flags_t        flags_in,
  output logic [DATA_W-1:0] y,
  output alu_flags_t        flags_out,
  output logic              is_cmp
);

  localparam int unsigned MSB = DATA_W - 1;

  logic              arith;
  logic              inv_a;
  logic              inv_b;
  logic              cin;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              ovf;
  logic [DATA_W-1:0] logic_y;

  // Adder control: subtract is A + ~B + 1, carry-chained forms use C.
  always_comb begin
    arith = 1'b1;
    inv_a = 1'b0;
    inv_b = 1'b0;
    cin   = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: ;
      OP_ADC:         cin = flags_in.c;
      OP_SUB, OP_CMP: begin inv_b = 1'b1; cin = 1'b1; end
      OP_SBC:         begin inv_b = 1'b1; cin = flags_in.c; end
      OP_RSB:         begin inv_a = 1'b1; cin = 1'b1; end
      OP_RSC:         begin inv_a = 1'b1; cin = flags_in.c; end
      default:        arith = 1'b0;
    endcase
  end

  alu_adder_unit #(.DATA_W(DATA_W)) u_adder (
    .a     (a),
    .b     (b),
    .inv_a (inv_a),
    .inv_b (inv_b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .ovf   (ovf)
  );

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .op (op),
    .a  (a),
    .b  (b),
    .y  (logic_y)
  );

  always_comb begin
    y           = arith ? sum : logic_y;
    is_cmp      = op_is_compare(op);
    flags_out.n = y[MSB];
    flags_out.z = (y == '0);
    flags_out.c = arith ? cout : shift_c;
    flags_out.v = arith ? ovf  : flags_in.v;
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              shift_carry,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [3:0]        flags
);

  alu_op_e    op;
  alu_flags_t flags_q;
  alu_flags_t flags_d;
  alu_flags_t core_flags;
  logic       core_cmp;
  logic       flag_en;

  assign op = alu_op_e'(opcode);

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .shift_c   (shift_carry),
    .flags_in  (flags_q),
    .y         (result),
    .flags_out (core_flags),
    .is_cmp    (core_cmp)
  );

  // Next-state logic
  always_comb begin
    flag_en = op_valid && (set_flags || core_cmp);
    flags_d = core_flags;
    wr_en   = op_valid && !core_cmp;
  end

  // Flag register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  // R6: no update requested -> flags hold
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || (!set_flags && opcode[3:2] != 2'b10)) |=> $stable(flags));

  // R5: compare/test opcodes never write
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[3:2] == 2'b10) |-> !wr_en);

  // R9: Z follows the result presented at the updating edge
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (set_flags || opcode[3:2] == 2'b10)) |=>
      (flags[2] == ($past(result) == '0)));

  // R9: N follows result bit 31
  p_neg_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (set_flags || opcode[3:2] == 2'b10)) |=>
      (flags[3] == $past(result[DATA_W-1])));

  // R8: logical update keeps V and loads C from the shifter
  p_logic_v_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_flags && (opcode == 4'd0 || opcode == 4'd1 || opcode >= 4'd12)) |=>
      (flags[0] == $past(flags[0]) && flags[1] == $past(shift_carry)));

endmodule

// File: tb/alu_flag_unit_tb_top.sv
module alu_flag_unit_tb_top;

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic        cin;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 25;

  // {op, s, a, b, shift_carry, preset C, result, wr_en, flags NZCV, requirement}
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 32'hF0F0_FFFF, 32'h0FF0_00FF, 1'b1, 1'b0, 32'h00F0_00FF, 1'b1, 4'b0010, 8'd1},  // R1 AND
    '{4'd1,  1'b1, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b0, 1'b1, 32'hF0F0_0F0F, 1'b1, 4'b1000, 8'd1},  // R1 EOR
    '{4'd12, 1'b0, 32'h0000_1200, 32'h0000_0034, 1'b0, 1'b1, 32'h0000_1234, 1'b1, 4'b0010, 8'd1},  // R1 ORR
    '{4'd14, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 4'b0110, 8'd1},  // R1 BIC
    '{4'd13, 1'b1, 32'hDEAD_BEEF, 32'h8000_0000, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 4'b1000, 8'd2},  // R2 MOV
    '{4'd15, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 4'b0100, 8'd2},  // R2 MVN
    '{4'd4,  1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 4'b1001, 8'd10}, // R10 ADD overflow
    '{4'd4,  1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 4'b0110, 8'd7},  // R7 ADD carry
    '{4'd2,  1'b1, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 32'h0000_0002, 1'b1, 4'b0010, 8'd7},  // R7 SUB no borrow
    '{4'd2,  1'b1, 32'h0000_0003, 32'h0000_0005, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b1, 4'b1000, 8'd7},  // R7 SUB borrow
    '{4'd2,  1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b1, 4'b0011, 8'd10}, // R10 SUB overflow
    '{4'd3,  1'b1, 32'h0000_0003, 32'h0000_000A, 1'b0, 1'b0, 32'h0000_0007, 1'b1, 4'b0010, 8'd3},  // R3 RSB
    '{4'd3,  1'b1, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'b1000, 8'd3},  // R3 RSB borrow
    '{4'd5,  1'b1, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1, 32'h0000_0004, 1'b1, 4'b0000, 8'd4},  // R4 ADC carry in
    '{4'd5,  1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 4'b0110, 8'd4},  // R4 ADC wrap
    '{4'd6,  1'b1, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 4'b0010, 8'd4},  // R4 SBC borrow in
    '{4'd6,  1'b1, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1, 32'h0000_0002, 1'b1, 4'b0010, 8'd4},  // R4 SBC no borrow
    '{4'd6,  1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'b1000, 8'd4},  // R4 SBC 0-0-1
    '{4'd7,  1'b1, 32'h0000_0003, 32'h0000_000A, 1'b0, 1'b0, 32'h0000_0006, 1'b1, 4'b0010, 8'd4},  // R4 RSC
    '{4'd10, 1'b0, 32'h0000_0004, 32'h0000_0004, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'b0110, 8'd5},  // R5 CMP equal
    '{4'd11, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'b0111, 8'd5},  // R5 CMN overflow
    '{4'd8,  1'b0, 32'h0000_000F, 32'h0000_00F0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 4'b0110, 8'd5},  // R5 TST
    '{4'd9,  1'b0, 32'h8000_0001, 32'h0000_0001, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 4'b1000, 8'd5},  // R5 TEQ
    '{4'd4,  1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 4'b0010, 8'd6},  // R6 no S
    '{4'd7,  1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'b1000, 8'd4}   // R4 RSC borrow
  };

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  opcode;
  logic        set_flags;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        shift_carry;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] got_res;
  logic        got_we;

  alu_flag_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .opcode      (opcode),
    .set_flags   (set_flags),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .shift_carry (shift_carry),
    .result      (result),
    .wr_en       (wr_en),
    .flags       (flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply one operation; capture combinational outputs, then post-edge flags.
  task automatic step(input logic [3:0] op, input logic s, input logic [31:0] a,
                      input logic [31:0] b, input logic sc, input logic v);
    @(negedge clk);
    op_valid = v; opcode = op; set_flags = s;
    opnd_a = a; opnd_b = b; shift_carry = sc;
    #2;
    got_res = result;
    got_we  = wr_en;
    @(posedge clk);
    #2;
  endtask

  // Leave flags at {0,0,c,0}
  task automatic preset(input logic c);
    step(4'd4, 1'b1, 32'h0, 32'h0, 1'b0, 1'b1);
    step(4'd13, 1'b1, 32'h0, 32'h1, c, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = 4'd0; set_flags = 1'b0;
    opnd_a = '0; opnd_b = '0; shift_carry = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 flags in reset", {28'h0, flags}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      preset(VECS[i].cin);
      step(VECS[i].op, VECS[i].s, VECS[i].a, VECS[i].b, VECS[i].sc, 1'b1);
      chk($sformatf("R%0d vec%0d result", VECS[i].rq, i), got_res, VECS[i].res);
      chk($sformatf("R5 vec%0d wr_en (req R%0d)", i, VECS[i].rq), {31'h0, got_we}, {31'h0, VECS[i].we});
      chk($sformatf("R%0d vec%0d flags", VECS[i].rq, i), {28'h0, flags}, {28'h0, VECS[i].fl});
    end

    // R8: logical update keeps V=1 and takes C from the shifter
    step(4'd4, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
    chk("R10 overflow preset", {28'h0, flags}, 32'h9);
    step(4'd13, 1'b1, 32'h0, 32'h5, 1'b1, 1'b1);
    chk("R8 V kept, C from shifter", {28'h0, flags}, 32'h3);

    // R6/R5: op_valid low blocks update and write
    step(4'd2, 1'b1, 32'h0, 32'h1, 1'b0, 1'b0);
    chk("R5 wr_en idle", {31'h0, got_we}, 32'h0);
    chk("R6 flags hold when idle", {28'h0, flags}, 32'h3);

    // R2: MOV ignores first operand
    step(4'd13, 1'b0, 32'hFFFF_FFFF, 32'h0000_00A5, 1'b0, 1'b1);
    chk("R2 MOV ignores a", got_res, 32'h0000_00A5);

    // R11: reset mid-run clears flags
    step(4'd4, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R11 async reset clears flags", {28'h0, flags}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule